// File: doc/BRIEF.md
# NAND cache program sequencer

This block is a host-side engine that writes a run of consecutive pages into an 8-bit asynchronous NAND flash using the cached program flow. Page data arrives as a valid/ready byte stream. While the flash programs one page into its array, the sequencer is already loading the next page into the flash's cache register. The flash's status register paces this pipeline.

A run is started with a first row address and a page count. A run must stay inside one erase block. A request that would leave the block, or that asks for zero pages, is refused with a single-cycle reject pulse, and no bus traffic follows. For each page the sequencer sends a load command, five address cycles, the page bytes and a close command. It then polls status until the flash may continue.

Pass/fail results come out one page late. The result of page N-1 is read from the cached-error bit after page N has been closed. The result of the final page is read from the array-error bit once programming has fully finished. Every page gets exactly one report, in page order.

Top module: `nand_cp_seq`

## Requirements
- R1: After reset, busy, reject, in_ready, bus_we, bus_re, res_valid and done are all 0.
- R2: A start with page_cnt = 0, or with (start_row mod PAGES_PER_BLK) + page_cnt > PAGES_PER_BLK, gives a one-cycle reject pulse. No bus write follows, and busy stays 0.
- R3: For page i of an accepted run, the bus carries a command cycle 80h (bus_cle=1). It then carries five address cycles (bus_ale=1): 00h, 00h, then bits 7:0, 15:8 and 23:16 of row start_row+i.
- R4: Each page carries exactly PAGE_BYTES data cycles (bus_cle=bus_ale=0). Their values are the accepted stream bytes in arrival order. No data write is made while in_valid is 0.
- R5: Every page except the last is closed with command 15h. The last page is closed with command 10h.
- R6: Each close is followed by one status command 70h and then by status reads (bus_re=1). The reads continue until bit 6 of bus_din is 1 for a non-final page, or until bit 5 is 1 for the final page. Only then is any status bit used or the next page started.
- R7: After page i (i>0, not final) is ready, page i-1 is reported with res_valid=1, res_page=i-1 and res_fail = bus_din bit 1. Page 0 of a multi-page run gives no report at that point.
- R8: After the final page N is ready, page N-1 (if N>0) is reported with fail = bit 1. Page N is then reported with fail = bit 0, and done pulses together with that last report.
- R9: busy is 1 from an accepted start until done. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request pulse |
| start_row | input | ROW_W | First row address of the run |
| page_cnt | input | CNT_W | Number of pages to write |
| in_data | input | 8 | Page data byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Sequencer accepts a byte this cycle |
| bus_cle | output | 1 | Current write cycle is a command |
| bus_ale | output | 1 | Current write cycle is an address |
| bus_we | output | 1 | One write cycle on the flash bus |
| bus_re | output | 1 | One status read cycle on the flash bus |
| bus_dq | output | 8 | Byte driven on the flash bus |
| bus_din | input | 8 | Status byte returned by the flash |
| busy | output | 1 | A run is in progress |
| reject | output | 1 | Start request refused |
| res_valid | output | 1 | A page result is present |
| res_page | output | CNT_W | Page index of the result |
| res_fail | output | 1 | Page failed to program |
| done | output | 1 | Last result of the run |

## Verification
The assertions assume that bus_din changes only between sampling edges. They also assume that the stream holds in_valid and in_data steady until the byte is taken. The bench meets both assumptions: it drives the status register and the stream half a cycle away from the design's edge, and it never withdraws a byte. Its flash model returns inverted error bits while the ready bits are low, so a result sampled before the pipeline allows it shows up as a wrong fail flag. The model also lengthens each cache-busy time by the time left on the array, as the cached flow requires.

// File: rtl/nand_cp_pkg.sv
package nand_cp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_ADDR, ST_DATA, ST_CLOSE, ST_STCMD, ST_STRD, ST_FIN
  } cp_state_t;

  localparam logic [7:0] OP_LOAD   = 8'h80;
  localparam logic [7:0] OP_CACHE  = 8'h15;
  localparam logic [7:0] OP_CONF   = 8'h10;
  localparam logic [7:0] OP_STATUS = 8'h70;

  localparam int SB_CACHE_RDY = 6;
  localparam int SB_ARRAY_RDY = 5;
  localparam int SB_PREV_ERR  = 1;
  localparam int SB_CUR_ERR   = 0;

  // A run fits when it is non-empty and ends at or before the block end
  function automatic logic run_fits(int unsigned offs, int unsigned cnt,
                                    int unsigned ppb);
    return (cnt != 0) && (offs + cnt <= ppb);
  endfunction

  // Address cycle idx of five: two zero column bytes, then row LSB first
  function automatic logic [7:0] addr_cycle(logic [23:0] row, logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd2:    b = row[7:0];
      3'd3:    b = row[15:8];
      3'd4:    b = row[23:16];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/nand_cp_guard.sv
module nand_cp_guard #(
  parameter int ROW_W         = 16,
  parameter int CNT_W         = 4,
  parameter int PAGES_PER_BLK = 4
) (
  input  logic [ROW_W-1:0] row,
  input  logic [CNT_W-1:0] cnt,
  output logic             ok
);
  import nand_cp_pkg::*;

  logic [31:0] offs;

  always_comb begin
    offs = 32'(row) % PAGES_PER_BLK;
    ok   = run_fits(offs, 32'(cnt), PAGES_PER_BLK);
  end
endmodule

// File: rtl/nand_cp_addrgen.sv
module nand_cp_addrgen #(
  parameter int ROW_W = 16
) (
  input  logic [ROW_W-1:0] row,
  input  logic [2:0]       idx,
  output logic [7:0]       abyte
);
  import nand_cp_pkg::*;

  logic [23:0] row24;

  generate
    if (ROW_W >= 24) begin : g_trim
      assign row24 = row[23:0];
    end else begin : g_pad
      assign row24 = {{(24-ROW_W){1'b0}}, row};
    end
  endgenerate

  assign abyte = addr_cycle(row24, idx);
endmodule

// File: rtl/nand_cp_status.sv
module nand_cp_status (
  input  logic [7:0] stat,
  input  logic       final_pg,
  output logic       go,
  output logic       prev_fail,
  output logic       cur_fail
);
  import nand_cp_pkg::*;

  assign go        = final_pg ? stat[SB_ARRAY_RDY] : stat[SB_CACHE_RDY];
  assign prev_fail = stat[SB_PREV_ERR];
  assign cur_fail  = stat[SB_CUR_ERR];
endmodule

// File: rtl/nand_cp_seq.sv
module nand_cp_seq #(
  parameter int ROW_W         = 16,
  parameter int CNT_W         = 4,
  parameter int PAGE_BYTES    = 8,
  parameter int PAGES_PER_BLK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] start_row,
  input  logic [CNT_W-1:0] page_cnt,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             bus_cle,
  output logic             bus_ale,
  output logic             bus_we,
  output logic             bus_re,
  output logic [7:0]       bus_dq,
  input  logic [7:0]       bus_din,
  output logic             busy,
  output logic             reject,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_page,
  output logic             res_fail,
  output logic             done
);
  import nand_cp_pkg::*;

  localparam int BYTE_W = $clog2(PAGE_BYTES + 1);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);

  cp_state_t        state;
  logic [ROW_W-1:0] row_q, first_q;
  logic [CNT_W-1:0] cnt_q, pidx;
  logic [2:0]       aidx;
  logic [BYTE_W-1:0] bidx;
  logic             cur_fail_q;

  // named internal events
  logic req_ok, page_last, data_hs, addr_done, page_full;
  logic stat_go, st_prev_fail, st_cur_fail;
  logic [7:0] addr_b;

  nand_cp_guard #(.ROW_W(ROW_W), .CNT_W(CNT_W), .PAGES_PER_BLK(PAGES_PER_BLK))
    u_guard (.row(start_row), .cnt(page_cnt), .ok(req_ok));

  nand_cp_addrgen #(.ROW_W(ROW_W))
    u_addr (.row(row_q), .idx(aidx), .abyte(addr_b));

  nand_cp_status u_stat (.stat(bus_din), .final_pg(page_last), .go(stat_go),
                         .prev_fail(st_prev_fail), .cur_fail(st_cur_fail));

  assign page_last = (pidx == cnt_q - CNT_W'(1));
  assign data_hs   = (state == ST_DATA) && in_valid;
  assign addr_done = (aidx == 3'd4);
  assign page_full = (bidx == LAST_BYTE);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    bus_we = 1'b0; bus_cle = 1'b0; bus_ale = 1'b0; bus_re = 1'b0;
    bus_dq = 8'h00; in_ready = 1'b0;
    case (state)
      ST_LOAD:  begin bus_we = 1'b1; bus_cle = 1'b1; bus_dq = OP_LOAD; end
      ST_ADDR:  begin bus_we = 1'b1; bus_ale = 1'b1; bus_dq = addr_b; end
      ST_DATA:  begin in_ready = 1'b1; bus_we = in_valid; bus_dq = in_data; end
      ST_CLOSE: begin
        bus_we = 1'b1; bus_cle = 1'b1;
        bus_dq = page_last ? OP_CONF : OP_CACHE;
      end
      ST_STCMD: begin bus_we = 1'b1; bus_cle = 1'b1; bus_dq = OP_STATUS; end
      ST_STRD:  bus_re = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      row_q <= '0; first_q <= '0; cnt_q <= '0; pidx <= '0;
      aidx <= '0; bidx <= '0; cur_fail_q <= 1'b0;
      reject <= 1'b0; res_valid <= 1'b0; res_page <= '0;
      res_fail <= 1'b0; done <= 1'b0;
    end else begin
      reject    <= 1'b0;
      res_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (req_ok) begin
            row_q <= start_row; first_q <= start_row;
            cnt_q <= page_cnt; pidx <= '0;
            state <= ST_LOAD;
          end else begin
            reject <= 1'b1;
          end
        end
        ST_LOAD: begin aidx <= '0; state <= ST_ADDR; end
        ST_ADDR: begin
          aidx <= aidx + 3'd1;
          if (addr_done) begin bidx <= '0; state <= ST_DATA; end
        end
        ST_DATA: if (data_hs) begin
          bidx <= bidx + BYTE_W'(1);
          if (page_full) state <= ST_CLOSE;
        end
        ST_CLOSE: state <= ST_STCMD;
        ST_STCMD: state <= ST_STRD;
        ST_STRD: if (stat_go) begin
          if (pidx != '0) begin
            res_valid <= 1'b1;
            res_page  <= pidx - CNT_W'(1);
            res_fail  <= st_prev_fail;
          end
          if (page_last) begin
            cur_fail_q <= st_cur_fail;
            state      <= ST_FIN;
          end else begin
            pidx  <= pidx + CNT_W'(1);
            row_q <= row_q + ROW_W'(1);
            state <= ST_LOAD;
          end
        end
        ST_FIN: begin
          res_valid <= 1'b1; res_page <= pidx; res_fail <= cur_fail_q;
          done <= 1'b1; state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_we && !bus_re && !in_ready)); // R1
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy); // R2
  AST_STAY_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((32'(row_q) / PAGES_PER_BLK) == (32'(first_q) / PAGES_PER_BLK))); // R2
  AST_CTRL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cle && bus_ale)); // R3
  AST_DATA_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_cle && !bus_ale) |-> (in_valid && in_ready)); // R4
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re)); // R6
  AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_page < cnt_q)); // R7
  AST_DONE_WITH_RES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_valid && !busy)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done)); // R9
endmodule

// File: tb/nand_cp_seq_test.sv
module nand_cp_seq_test;
  localparam int ROW_W = 16, CNT_W = 4, PB = 8, PPB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [ROW_W-1:0] start_row = '0;
  logic [CNT_W-1:0] page_cnt = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready, bus_cle, bus_ale, bus_we, bus_re;
  logic [7:0] bus_dq, bus_din;
  logic busy, reject, res_valid, res_fail, done;
  logic [CNT_W-1:0] res_page;

  nand_cp_seq #(.ROW_W(ROW_W), .CNT_W(CNT_W), .PAGE_BYTES(PB), .PAGES_PER_BLK(PPB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row), .page_cnt(page_cnt),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .bus_cle(bus_cle), .bus_ale(bus_ale), .bus_we(bus_we), .bus_re(bus_re),
    .bus_dq(bus_dq), .bus_din(bus_din), .busy(busy), .reject(reject),
    .res_valid(res_valid), .res_page(res_page), .res_fail(res_fail), .done(done));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic clr = 1'b0;
  logic [7:0] fmask = '0;

  // flash model state
  int cache_c = 0, arr_c = 0, pg_seen = 0;
  logic prev_f = 1'b0, cur_f = 1'b0;
  logic c6, c5;
  assign c6 = (cache_c == 0);
  assign c5 = (cache_c == 0) && (arr_c == 0);
  assign bus_din = {1'b0, c6, c5, 3'b000, c6 ? prev_f : ~prev_f, c5 ? cur_f : ~cur_f};

  // observation logs
  logic [9:0] wlog [0:127];
  int log_n = 0;
  logic [CNT_W-1:0] rpage [0:15];
  logic rfail [0:15];
  int res_n = 0, rej_n = 0, done_n = 0, done_at = -1;
  logic hs_pend = 1'b0;
  logic [7:0] data_ctr = '0;
  logic [7:0] lfsr = 8'hA5;

  always @(negedge clk) begin
    cycles++;
    if (clr) begin
      cache_c = 0; arr_c = 0; pg_seen = 0; prev_f = 0; cur_f = 0;
      log_n = 0; res_n = 0; rej_n = 0; done_n = 0; done_at = -1;
    end else begin
      if (cache_c > 0) cache_c--;
      if (arr_c > 0) arr_c--;
      if (bus_we) begin
        if (log_n < 128) wlog[log_n] = {bus_cle, bus_ale, bus_dq};
        log_n++;
        if (bus_cle && bus_dq == 8'h80) pg_seen++;
        if (bus_cle && (bus_dq == 8'h15 || bus_dq == 8'h10)) begin
          prev_f = cur_f;
          cur_f = fmask[(pg_seen - 1) & 7];
          cache_c = arr_c + 2;
          arr_c = cache_c + 5;
        end
      end
      if (reject) rej_n++;
      if (res_valid) begin
        if (res_n < 16) begin rpage[res_n] = res_page; rfail[res_n] = res_fail; end
        if (done) done_at = res_n;
        res_n++;
      end
      if (done) done_n++;
    end
    hs_pend = in_valid && in_ready;
  end

  // stream driver, updates just after the edge that took a byte
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (hs_pend) begin data_ctr = data_ctr + 8'd1; in_data = data_ctr; in_valid = lfsr[0]; end
    else if (!in_valid) in_valid = lfsr[0];
    in_data = data_ctr;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(int row, int k);
    if (k < 2) return 8'h00;
    return 8'((row >> (8 * (k - 2))) & 255);
  endfunction

  task automatic run(input int row, input int cnt, input int run_id);
    int offs, pos, d, e;
    logic fits, ok;
    offs = row % PPB;
    fits = (cnt != 0) && (offs + cnt <= PPB);
    fmask = 8'((run_id * 37 + 11) & 255);
    @(negedge clk); clr = 1'b1;
    data_ctr = 8'(run_id * 3); in_data = data_ctr;
    @(negedge clk); clr = 1'b0;
    start = 1'b1; start_row = ROW_W'(row); page_cnt = CNT_W'(cnt);
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 4000; t++) begin
      if (done_n > 0 || rej_n > 0) break;
      if (t == 15 && cnt >= 2) begin
        check(busy == 1'b1, "R9", busy, 1);
        start = 1'b1; start_row = '0; page_cnt = CNT_W'(1);
        @(negedge clk); start = 1'b0;
      end else @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9", busy, 0);
    if (!fits) begin
      check(rej_n == 1, "R2", rej_n, 1);
      check(log_n == 0, "R2", log_n, 0);
      check(res_n == 0 && done_n == 0, "R2", res_n, 0);
    end else begin
      check(rej_n == 0, "R2", rej_n, 0);
      check(log_n == cnt * (PB + 8), "R3", log_n, cnt * (PB + 8));
      pos = 0; d = run_id * 3;
      for (int p = 0; p < cnt && pos + PB + 8 <= log_n; p++) begin
        check(wlog[pos] == {2'b10, 8'h80}, "R3", wlog[pos], {2'b10, 8'h80}); pos++;
        for (int k = 0; k < 5; k++) begin
          e = {2'b01, exp_addr(row + p, k)};
          check(wlog[pos] == 10'(e), "R3", wlog[pos], e); pos++;
        end
        ok = 1'b1;
        for (int k = 0; k < PB; k++) begin
          if (wlog[pos] != {2'b00, 8'(d)}) ok = 1'b0;
          pos++; d++;
        end
        check(ok, "R4", p, p);
        e = (p == cnt - 1) ? {2'b10, 8'h10} : {2'b10, 8'h15};
        check(wlog[pos] == 10'(e), "R5", wlog[pos], e); pos++;
        check(wlog[pos] == {2'b10, 8'h70}, "R6", wlog[pos], {2'b10, 8'h70}); pos++;
      end
      check(res_n == cnt, "R7", res_n, cnt);
      for (int p = 0; p < cnt && p < 16; p++) begin
        check(rpage[p] == CNT_W'(p), "R7", rpage[p], p);
        check(rfail[p] == fmask[p], (p == cnt - 1) ? "R8" : "R7", rfail[p], fmask[p]);
      end
      check(done_n == 1 && done_at == cnt - 1, "R8", done_at, cnt - 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && reject == 0 && in_ready == 0, "R1", {busy, reject, in_ready}, 0);
    check(bus_we == 0 && bus_re == 0 && res_valid == 0 && done == 0, "R1",
          {bus_we, bus_re, res_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && bus_we == 0 && in_ready == 0, "R1", {busy, bus_we, in_ready}, 0);
    begin
      int id;
      id = 0;
      for (int s = 0; s < 12; s++) begin
        for (int c = 0; c < 6; c++) begin
          run((s < 8) ? s : (16'h3A7C + s - 8), c, id);
          id++;
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule